// File: doc/BRIEF.md
# Secondary Sample Point Bit Checker

When a CAN FD transmitter runs its data phase at a fast bit rate, the loop delay through the transceiver can exceed the time to the normal sample point. The transmitter can then no longer compare its own bit with the bus at that point. This block delays the regular sample strobe by an effective offset to form a secondary sample strobe. On each secondary strobe it compares the bus value with the bit that was transmitted for that bit time. A mismatch produces a one-cycle bit-error pulse.

The block does not copy the whole transmitted stream clock by clock into a second long delay line. It keeps only the bit driven at each sync segment, in a small FIFO. The FIFO is written at sync and read when the secondary strobe fires. The effective offset comes from the measured loop delay, from a software value, or from their saturated sum. A registered copy of the measured delay stays visible on its own port. Protocol control raises the checking-enable input for the data phase only. While that input is low the FIFO is held empty, so arbitration-phase bits are never compared.

Top module: `ssp_bit_checker`

## Requirements
- R1: `ssp_stb` is high exactly `eff_offset` clocks after a cycle with `sample_stb` high. With an offset of 0 it is high in the same cycle. It is never high otherwise.
- R2: The effective offset never exceeds 129. A selected source value above 129 is clamped to 129.
- R3: `ofs_mode` selects the offset source. 2'b00 selects `meas_delay` alone, 2'b01 selects `sw_offset` alone, and 2'b10 selects `meas_delay + sw_offset`. 2'b11 behaves like 2'b00.
- R4: In mode 2'b10 a sum above 129 saturates at 129.
- R5: One clock after the inputs change, `eff_offset` shows the offset in use and `meas_delay_rd` shows `meas_delay`, whatever the mode.
- R6: While `check_en` is high, `tx_bit` is pushed at each `sync_stb`, and the oldest entry is popped at each `ssp_stb`. `bit_err` pulses in the cycle after the pop when the popped bit differs from `rx_bit` sampled in the strobe cycle. `bit_err` is low otherwise.
- R7: A secondary strobe that finds the FIFO empty sets `fifo_fault` and produces no `bit_err`. `fifo_fault` stays set until reset.
- R8: A push into a full 4-entry FIFO without a pop in the same cycle sets `fifo_fault`. The pushed bit is dropped and the held bits stay intact.
- R9: While `check_en` is low, the FIFO is cleared and `bit_err` stays low. Bits pushed before the drop are never compared.
- R10: After reset, `ssp_stb`, `bit_err`, `fifo_fault` and `eff_offset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_en | input | 1 | Data-phase checking enable; low clears the FIFO |
| sync_stb | input | 1 | Sync-segment strobe of the current bit |
| sample_stb | input | 1 | Regular sample-point strobe |
| tx_bit | input | 1 | Bit being transmitted |
| rx_bit | input | 1 | Bus value as received |
| meas_delay | input | 8 | Measured loop delay in clocks |
| sw_offset | input | 8 | Software offset in clocks |
| ofs_mode | input | 2 | Offset source select |
| ssp_stb | output | 1 | Secondary (delayed) sample strobe |
| bit_err | output | 1 | One-cycle bit-error pulse |
| fifo_fault | output | 1 | Sticky underflow/overflow flag |
| eff_offset | output | 8 | Effective offset in use |
| meas_delay_rd | output | 8 | Registered copy of the measured delay |

## Verification
Frames are sent with every offset from 0 to 129. The loop delay equals the offset and the bus is inverted on a varying set of bits. This shows whether each compare uses the right queued bit and not a neighbour, including the case where up to four bits are in flight. Further frames use the software-only mode and the summed mode, to show that the strobe follows the selected source. Directed runs force an empty pop, a fifth push and a clear from dropping `check_en`. In each run a wrongly stored or stale bit would show up as a spurious error.

// File: rtl/ssp_pkg.sv
// Shared types for the secondary sample point bit checker.
package ssp_pkg;
    typedef enum logic [1:0] {
        OFS_MEAS = 2'b00,
        OFS_SW   = 2'b01,
        OFS_SUM  = 2'b10
    } ofs_mode_e;
endpackage

// File: rtl/ssp_offset_sel.sv
// Picks the effective secondary-sample offset from the measured delay and/or
// the software value, clamps it to MAX_OFS and registers it. Also registers a
// plain copy of the measured delay for observation.
// Assumes: source values are static while strobes are in flight.
module ssp_offset_sel
    import ssp_pkg::*;
#(
    parameter int OFS_W   = 8,
    parameter int MAX_OFS = 129
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [OFS_W-1:0] meas,
    input  logic [OFS_W-1:0] sw,
    output logic [OFS_W-1:0] ofs,
    output logic [OFS_W-1:0] meas_rd
);
    localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(MAX_OFS);

    logic [OFS_W:0]   raw;
    logic [OFS_W-1:0] sel;

    // Purpose: choose the source and saturate it.
    always_comb begin
        case (ofs_mode_e'(mode))
            OFS_SW:  raw = {1'b0, sw};
            OFS_SUM: raw = {1'b0, meas} + {1'b0, sw};
            default: raw = {1'b0, meas};
        endcase
        sel = (raw > LIMIT) ? LIMIT[OFS_W-1:0] : raw[OFS_W-1:0];
    end

    // Purpose: register the effective offset and the delay copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs     <= '0;
            meas_rd <= '0;
        end else begin
            ofs     <= sel;
            meas_rd <= meas;
        end
    end
endmodule

// File: rtl/ssp_strobe_delay.sv
// Delays the regular sample strobe by 'ofs' clocks through a shift line of
// STAGES-1 registers; offset 0 passes the strobe through combinationally.
// Assumes: ofs <= STAGES-1.
module ssp_strobe_delay #(
    parameter int STAGES = 130,
    parameter int OFS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_in,
    input  logic [OFS_W-1:0] ofs,
    output logic             stb_out
);
    localparam int REGS = STAGES - 1;

    logic [REGS-1:0]  line_q;
    logic [OFS_W-1:0] tap;

    // Purpose: shift the strobe one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= {line_q[REGS-2:0], stb_in};
    end

    // Purpose: select the tap matching the offset.
    always_comb begin
        tap     = ofs - 1'b1;
        stb_out = (ofs == '0) ? stb_in : line_q[tap];
    end
endmodule

// File: rtl/ssp_tx_fifo.sv
// Small bit FIFO holding the transmitted bit of each sync segment. Flags an
// overflow (push into full without pop, push dropped) and an underflow (pop
// while empty). A clear empties it.
// Assumes: DEPTH >= 2.
module ssp_tx_fifo #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic din,
    input  logic pop,
    output logic head,
    output logic empty,
    output logic overflow,
    output logic underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wr_q, rd_q;
    logic [AW:0]      cnt_q;
    logic             full, push_ok, pop_ok;

    // Purpose: status and accepted-operation decode.
    always_comb begin
        empty     = (cnt_q == '0);
        full      = (cnt_q == (AW+1)'(DEPTH));
        pop_ok    = pop && !empty;
        push_ok   = push && (!full || pop_ok);
        overflow  = push && full && !pop;
        underflow = pop && empty;
        head      = mem_q[rd_q];
    end

    // Purpose: pointer, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            if (!rst_n) mem_q <= '0;
        end else begin
            if (push_ok) begin
                mem_q[wr_q] <= din;
                wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (pop_ok) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end
endmodule

// File: rtl/ssp_bit_checker.sv
// Bit-error checker at a delayed (secondary) sample point for the fast data
// phase. Queues the bit sent at each sync segment and compares the oldest one
// with the bus at the secondary strobe. Faults on queue under/overflow are
// sticky until reset and suppress that comparison.
// Assumes: check_en is high only during the data phase.
module ssp_bit_checker #(
    parameter int STAGES     = 130,
    parameter int OFS_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_en,
    input  logic             sync_stb,
    input  logic             sample_stb,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic [OFS_W-1:0] meas_delay,
    input  logic [OFS_W-1:0] sw_offset,
    input  logic [1:0]       ofs_mode,
    output logic             ssp_stb,
    output logic             bit_err,
    output logic             fifo_fault,
    output logic [OFS_W-1:0] eff_offset,
    output logic [OFS_W-1:0] meas_delay_rd
);
    localparam int MAX_OFS = STAGES - 1;

    logic q_head, q_empty, q_ovf, q_udf;

    ssp_offset_sel #(.OFS_W(OFS_W), .MAX_OFS(MAX_OFS)) u_sel (
        .clk(clk), .rst_n(rst_n), .mode(ofs_mode), .meas(meas_delay),
        .sw(sw_offset), .ofs(eff_offset), .meas_rd(meas_delay_rd)
    );

    ssp_strobe_delay #(.STAGES(STAGES), .OFS_W(OFS_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .stb_in(sample_stb), .ofs(eff_offset),
        .stb_out(ssp_stb)
    );

    ssp_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(!check_en),
        .push(check_en && sync_stb), .din(tx_bit),
        .pop(check_en && ssp_stb), .head(q_head), .empty(q_empty),
        .overflow(q_ovf), .underflow(q_udf)
    );

    // Purpose: compare at the secondary strobe and keep the sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_err    <= 1'b0;
            fifo_fault <= 1'b0;
        end else begin
            bit_err <= check_en && ssp_stb && !q_empty && (q_head != rx_bit);
            if (check_en && (q_ovf || q_udf)) fifo_fault <= 1'b1;
        end
    end
endmodule

// Property checker attached to every ssp_bit_checker instance.
module ssp_bit_checker_sva #(
    parameter int OFS_W   = 8,
    parameter int MAX_OFS = 129
) (
    input logic             clk,
    input logic             rst_n,
    input logic             check_en,
    input logic             sample_stb,
    input logic             ssp_stb,
    input logic             bit_err,
    input logic             fifo_fault,
    input logic [OFS_W-1:0] eff_offset,
    input logic [OFS_W-1:0] meas_delay,
    input logic [OFS_W-1:0] meas_delay_rd
);
    p_zero_tap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_offset == '0) |-> (ssp_stb == sample_stb));
    p_offset_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eff_offset <= OFS_W'(MAX_OFS));
    p_meas_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (meas_delay_rd == $past(meas_delay)));
    p_err_after_ssp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_stb == 1'b0 |=> !bit_err);
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_fault |=> fifo_fault);
    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !check_en |=> !bit_err);
endmodule

bind ssp_bit_checker ssp_bit_checker_sva #(.OFS_W(OFS_W), .MAX_OFS(STAGES-1)) u_sva (
    .clk(clk), .rst_n(rst_n), .check_en(check_en), .sample_stb(sample_stb),
    .ssp_stb(ssp_stb), .bit_err(bit_err), .fifo_fault(fifo_fault),
    .eff_offset(eff_offset), .meas_delay(meas_delay), .meas_delay_rd(meas_delay_rd)
);

// File: tb/tb_ssp_bit_checker.sv
module tb_ssp_bit_checker;
    localparam int BITP = 40;
    localparam int SPT  = 30;
    localparam int NB   = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic check_en = 0, sync_stb = 0, sample_stb = 0, tx_bit = 1, rx_bit = 1;
    logic [7:0] meas_delay = 0, sw_offset = 0;
    logic [1:0] ofs_mode = 0;
    logic ssp_stb, bit_err, fifo_fault;
    logic [7:0] eff_offset, meas_delay_rd;

    int total = 0, bad = 0, cyc = 0;
    bit mon_on = 0, finished = 0;
    int qc[$];
    bit qe[$];
    bit pend_v = 0, pend_e = 0;
    int pend_c = 0;
    bit saw_err = 0;

    ssp_bit_checker dut (
        .clk(clk), .rst_n(rst_n), .check_en(check_en), .sync_stb(sync_stb),
        .sample_stb(sample_stb), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .meas_delay(meas_delay), .sw_offset(sw_offset), .ofs_mode(ofs_mode),
        .ssp_stb(ssp_stb), .bit_err(bit_err), .fifo_fault(fifo_fault),
        .eff_offset(eff_offset), .meas_delay_rd(meas_delay_rd)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (bit_err) saw_err = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) if (cyc > 190000) begin
        chk(0, "watchdog", cyc, 190000);
        summary();
    end

    // Monitor: pops expected strobe/error items and compares them.
    always @(negedge clk) if (mon_on) begin
        if (pend_v && cyc == pend_c) begin
            chk(bit_err == pend_e, "R6 bit_err", bit_err, pend_e);
            pend_v = 0;
        end else if (bit_err) chk(0, "R6 spurious bit_err", 1, 0);
        if (qc.size() > 0 && qc[0] == cyc) begin
            chk(ssp_stb == 1'b1, "R1 ssp_stb", ssp_stb, 1);
            pend_v = 1; pend_c = cyc + 1; pend_e = qe[0];
            void'(qc.pop_front()); void'(qe.pop_front());
        end else if (ssp_stb) chk(0, "R1 spurious ssp_stb", 1, 0);
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0; check_en = 0; sync_stb = 0; sample_stb = 0; tx_bit = 1; rx_bit = 1;
        repeat (3) step();
        rst_n = 1; step();
    endtask

    function automatic bit tx_at(input int t, input int pat);
        if (t < 0 || t >= NB*BITP) return 1'b1;
        return ((pat >> (t / BITP)) & 1) != 0;
    endfunction

    function automatic bit rx_at(input int t, input int d, input int pat, input int mask);
        int tt = t - d;
        bit f = 0;
        if (tt >= 0 && tt < NB*BITP) f = ((mask >> (tt / BITP)) & 1) != 0;
        return tx_at(tt, pat) ^ f;
    endfunction

    // Driver: sends one frame and queues expected strobe and error items.
    task automatic run_frame(input int mode, input int meas, input int sw,
                             input int k, input int d, input int pat, input int mask);
        ofs_mode = 2'(mode); meas_delay = 8'(meas); sw_offset = 8'(sw);
        repeat (3) step();
        mon_on = 1;
        check_en = 1;
        for (int t = 0; t < NB*BITP + 200; t++) begin
            sync_stb   = (t < NB*BITP) && (t % BITP == 0);
            sample_stb = (t < NB*BITP) && (t % BITP == SPT);
            tx_bit     = tx_at(t, pat);
            rx_bit     = rx_at(t, d, pat, mask);
            if (sample_stb) begin
                qc.push_back(cyc + k);
                qe.push_back(tx_at(t, pat) != rx_at(t + k, d, pat, mask));
            end
            step();
        end
        sync_stb = 0; sample_stb = 0;
        check_en = 0;
        step();
        chk(qc.size() == 0, "R1 all strobes seen", qc.size(), 0);
    endtask

    task automatic cfg_check(input int mode, input int meas, input int sw,
                             input int exp, input string req);
        ofs_mode = 2'(mode); meas_delay = 8'(meas); sw_offset = 8'(sw);
        step(); step();
        chk(eff_offset == 8'(exp), req, eff_offset, exp);
        chk(meas_delay_rd == 8'(meas), "R5 meas_delay_rd", meas_delay_rd, meas);
    endtask

    initial begin
        do_reset();
        // R10 reset state
        chk(ssp_stb == 0, "R10 ssp_stb", ssp_stb, 0);
        chk(bit_err == 0, "R10 bit_err", bit_err, 0);
        chk(fifo_fault == 0, "R10 fifo_fault", fifo_fault, 0);
        chk(eff_offset == 0, "R10 eff_offset", eff_offset, 0);

        // R3/R4/R2/R5 offset selection
        cfg_check(0, 40, 17, 40, "R3 mode 00");
        cfg_check(1, 40, 17, 17, "R3 mode 01");
        cfg_check(2, 20, 15, 35, "R3 mode 10");
        cfg_check(3, 44, 9, 44, "R3 mode 11");
        cfg_check(2, 100, 50, 129, "R4 sum saturate");
        cfg_check(0, 200, 0, 129, "R2 clamp measured");
        cfg_check(1, 3, 255, 129, "R2 clamp software");

        // R1/R6 sweep of every offset with matching loop delay
        for (int k = 0; k <= 129; k++)
            run_frame(0, k, 0, k, k, (k * 11 + 5) & 63, (k * 37 + 5) & 63);
        // R3 functional: software-only and summed sources
        run_frame(1, 90, 60, 60, 60, 6'b101101, 6'b010010);
        run_frame(2, 70, 25, 95, 95, 6'b110010, 6'b100001);
        run_frame(0, 10, 0, 10, 25, 6'b011011, 6'b000100);
        mon_on = 0;

        // R7 underflow: strobe with an empty FIFO
        do_reset();
        ofs_mode = 0; meas_delay = 5; step(); step();
        check_en = 1; saw_err = 0;
        sample_stb = 1; tx_bit = 0; rx_bit = 1; step(); sample_stb = 0;
        repeat (8) step();
        chk(fifo_fault == 1, "R7 underflow fault", fifo_fault, 1);
        chk(saw_err == 0, "R7 no bit_err", saw_err, 0);
        repeat (20) step();
        chk(fifo_fault == 1, "R7 sticky", fifo_fault, 1);

        // R8 overflow: fifth push is dropped, held bits intact
        do_reset();
        ofs_mode = 0; meas_delay = 0; step(); step();
        check_en = 1; saw_err = 0;
        for (int i = 0; i < 5; i++) begin
            sync_stb = 1; tx_bit = (i < 4); step(); sync_stb = 0; step();
        end
        chk(fifo_fault == 1, "R8 overflow fault", fifo_fault, 1);
        rx_bit = 1;
        for (int i = 0; i < 5; i++) begin
            sample_stb = 1; step(); sample_stb = 0; step();
        end
        step();
        chk(saw_err == 0, "R8 dropped bit not compared", saw_err, 0);

        // R9 clear: bits pushed before check_en drops are never compared
        do_reset();
        ofs_mode = 0; meas_delay = 0; step(); step();
        check_en = 1; saw_err = 0;
        for (int i = 0; i < 2; i++) begin
            sync_stb = 1; tx_bit = 0; step(); sync_stb = 0; step();
        end
        check_en = 0; rx_bit = 1;
        sample_stb = 1; step(); sample_stb = 0; step();
        chk(saw_err == 0 && fifo_fault == 0, "R9 idle while disabled", saw_err, 0);
        check_en = 1;
        sample_stb = 1; step(); sample_stb = 0; step(); step();
        chk(saw_err == 0, "R9 cleared no bit_err", saw_err, 0);
        chk(fifo_fault == 1, "R9 cleared gives underflow", fifo_fault, 1);

        summary();
    end
endmodule